// File: doc/BRIEF.md
# Iterative 128-bit Substitution-Permutation Cipher Core

This core encrypts or decrypts one 128-bit block with a 32-round substitution-permutation network, spending one clock per step. The block is held as four 32-bit words. A round adds a 128-bit round key, passes every bit column of the four words through a 4-bit substitution table, and then scrambles the words with rotations, XORs and discarding left shifts. Decryption applies the inverse tables and the inverse scramble in the opposite round order.

The core does not expand keys. It presents the index of the round key it needs on `key_idx_o`, and the surrounding logic returns that key on `subkey_i` in the same cycle, for example from a small key store addressed directly by the index. A pulse on `start_i` while the core is idle loads the block and the direction. Thirty-three steps later, `done_o` marks the result on `block_o` for one cycle.

Top module: `spn_round_core`

## Requirements
- R1: After reset, `done_o` is 0, `key_idx_o` is 0 and `block_o` is all zeros.
- R2: A `start_i` sampled high at a clock edge while the core is idle is accepted. Counting that edge as edge 0, `done_o` is high after edge 33 for exactly one cycle.
- R3: Word k of the state is `block_i[32k+31:32k]`. The substitution at bit column j takes the nibble {word3[j], word2[j], word1[j], word0[j]}, with word0 as its least significant bit, and writes the result bits back to column j in the same order.
- R4: Encryption step r (0..31) XORs key r into the state, then applies forward table (r mod 8), then applies the forward scramble, except at r = 31, which has no scramble. Step 32 XORs key 32. The tables are those in `spn_pkg`.
- R5: The forward scramble is, in this order: rotate word0 left by 13 and word2 left by 3; word1 ^= word0^word2 and word3 ^= word2^(word0<<3); rotate word1 left by 1 and word3 left by 7; word0 ^= word1^word3 and word2 ^= word3^(word1<<7); rotate word0 left by 5 and word2 left by 22. The <<3 and <<7 are logical shifts that drop the bits shifted out.
- R6: Decryption step 0 XORs key 32. Step s (1..32) works on round r = 32-s: it applies the inverse scramble (except for r = 31), then inverse table (r mod 8), then XORs key r. Decrypting an encrypted block with the same keys returns the original block.
- R7: While busy, `key_idx_o` shows the index of the key that the current step consumes: 0,1,...,32 when encrypting and 32,31,...,0 when decrypting. `subkey_i` is sampled at the edge that ends the step. While idle, `key_idx_o` is 0.
- R8: A `start_i` that arrives while the core is busy is ignored. It changes neither the direction nor the block being processed.
- R9: `done_o` never stays high for two cycles in a row. `block_o` holds the result from the `done_o` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; honoured only while idle |
| decrypt_i | input | 1 | Direction captured with the start: 1 decrypts, 0 encrypts |
| block_i | input | 128 | Input block, captured with the start |
| key_idx_o | output | 6 | Index (0..32) of the round key needed this cycle |
| subkey_i | input | 128 | Round key selected by `key_idx_o`, word k in bits [32k+31:32k] |
| done_o | output | 1 | One-cycle pulse: the result is on `block_o` |
| block_o | output | 128 | Result block |

## Verification
Two events can land in the same cycle. The first is a new start in the cycle that `done_o` is high: the core is already idle then, so the start is accepted, and the bench checks that the old result is readable in that cycle and that the new operation completes correctly, with its own key sequence. The second is a start during a busy run: the bench raises `start_i` in the middle of an operation, with the other direction and a different block. It judges the run by the unchanged key index sequence and by a result that still matches the model of the original request.

// File: rtl/spn_pkg.sv
package spn_pkg;

    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 4;
    localparam int BLOCK_W  = WORD_W * N_WORDS;
    localparam int N_TABLES = 8;

    typedef logic [WORD_W-1:0] word_t;

    // Each row packs table entry 0 in the top nibble, entry 15 in the bottom.
    function automatic logic [63:0] sbox_row(input logic [2:0] idx);
        logic [63:0] row;
        case (idx)
            3'd0: row = {4'd3, 4'd8, 4'd15, 4'd1, 4'd10, 4'd6, 4'd5, 4'd11,
                         4'd14, 4'd13, 4'd4, 4'd2, 4'd7, 4'd0, 4'd9, 4'd12};
            3'd1: row = {4'd15, 4'd12, 4'd2, 4'd7, 4'd9, 4'd0, 4'd5, 4'd10,
                         4'd1, 4'd11, 4'd14, 4'd8, 4'd6, 4'd13, 4'd3, 4'd4};
            3'd2: row = {4'd8, 4'd6, 4'd7, 4'd9, 4'd3, 4'd12, 4'd10, 4'd15,
                         4'd13, 4'd1, 4'd14, 4'd4, 4'd0, 4'd11, 4'd5, 4'd2};
            3'd3: row = {4'd0, 4'd15, 4'd11, 4'd8, 4'd12, 4'd9, 4'd6, 4'd3,
                         4'd13, 4'd1, 4'd2, 4'd4, 4'd10, 4'd7, 4'd5, 4'd14};
            3'd4: row = {4'd1, 4'd15, 4'd8, 4'd3, 4'd12, 4'd0, 4'd11, 4'd6,
                         4'd2, 4'd5, 4'd4, 4'd10, 4'd9, 4'd14, 4'd7, 4'd13};
            3'd5: row = {4'd15, 4'd5, 4'd2, 4'd11, 4'd4, 4'd10, 4'd9, 4'd12,
                         4'd0, 4'd3, 4'd14, 4'd8, 4'd13, 4'd6, 4'd7, 4'd1};
            3'd6: row = {4'd7, 4'd2, 4'd12, 4'd5, 4'd8, 4'd4, 4'd6, 4'd11,
                         4'd14, 4'd9, 4'd1, 4'd15, 4'd13, 4'd3, 4'd10, 4'd0};
            default: row = {4'd1, 4'd13, 4'd15, 4'd0, 4'd14, 4'd8, 4'd2, 4'd11,
                         4'd7, 4'd4, 4'd12, 4'd10, 4'd9, 4'd3, 4'd5, 4'd6};
        endcase
        return row;
    endfunction

    function automatic logic [3:0] sbox_fwd(input logic [2:0] idx, input logic [3:0] nib);
        logic [63:0] row;
        row = sbox_row(idx);
        return row[(60 - 4*int'(nib)) +: 4];
    endfunction

    // Inverse found by search over the forward table, so the two can never disagree.
    function automatic logic [3:0] sbox_inv(input logic [2:0] idx, input logic [3:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if (sbox_fwd(idx, 4'(i)) == v) r = 4'(i);
        end
        return r;
    endfunction

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    typedef struct packed {
        logic                busy;
        logic                dec;
        logic                done;
        logic [5:0]          step;
        logic [BLOCK_W-1:0]  state;
    } core_t;

endpackage

// File: rtl/spn_bitslice.sv
module spn_bitslice
    import spn_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [2:0]          sel_i,
    input  logic [BLOCK_W-1:0]  din_i,
    output logic [BLOCK_W-1:0]  dout_o
);
    for (genvar j = 0; j < WORD_W; j++) begin : g_col
        logic [3:0] nib_in;
        logic [3:0] nib_out;
        assign nib_in = {din_i[3*WORD_W+j], din_i[2*WORD_W+j],
                         din_i[WORD_W+j],   din_i[j]};
        if (INVERSE) begin : g_inv
            assign nib_out = sbox_inv(sel_i, nib_in);
        end else begin : g_fwd
            assign nib_out = sbox_fwd(sel_i, nib_in);
        end
        assign dout_o[j]            = nib_out[0];
        assign dout_o[WORD_W+j]     = nib_out[1];
        assign dout_o[2*WORD_W+j]   = nib_out[2];
        assign dout_o[3*WORD_W+j]   = nib_out[3];
    end
endmodule

// File: rtl/spn_mix.sv
module spn_mix
    import spn_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BLOCK_W-1:0]  din_i,
    output logic [BLOCK_W-1:0]  dout_o
);
    word_t i0, i1, i2, i3;
    assign {i3, i2, i1, i0} = din_i;

    if (!INVERSE) begin : g_fwd
        always_comb begin
            word_t a0, a1, a2, a3;
            a0 = rotl(i0, 13);
            a2 = rotl(i2, 3);
            a1 = i1 ^ a0 ^ a2;
            a3 = i3 ^ a2 ^ (a0 << 3);
            a1 = rotl(a1, 1);
            a3 = rotl(a3, 7);
            a0 = a0 ^ a1 ^ a3;
            a2 = a2 ^ a3 ^ (a1 << 7);
            a0 = rotl(a0, 5);
            a2 = rotl(a2, 22);
            dout_o = {a3, a2, a1, a0};
        end
    end else begin : g_inv
        always_comb begin
            word_t b0, b1, b2, b3;
            b2 = rotr(i2, 22);
            b0 = rotr(i0, 5);
            b2 = b2 ^ i3 ^ (i1 << 7);
            b0 = b0 ^ i1 ^ i3;
            b3 = rotr(i3, 7);
            b1 = rotr(i1, 1);
            b3 = b3 ^ b2 ^ (b0 << 3);
            b1 = b1 ^ b0 ^ b2;
            b2 = rotr(b2, 3);
            b0 = rotr(b0, 13);
            dout_o = {b3, b2, b1, b0};
        end
    end
endmodule

// File: rtl/spn_round_core.sv
module spn_round_core
    import spn_pkg::*;
#(
    parameter int NUM_ROUNDS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                decrypt_i,
    input  logic [127:0]        block_i,
    output logic [5:0]          key_idx_o,
    input  logic [127:0]        subkey_i,
    output logic                done_o,
    output logic [127:0]        block_o
);
    localparam int IDX_W = 6;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);
    localparam logic [IDX_W-1:0] TAIL_RND = IDX_W'(NUM_ROUNDS - 1);

    core_t q, d;

    logic [IDX_W-1:0]   dec_rnd;
    logic [BLOCK_W-1:0] keyed;
    logic [BLOCK_W-1:0] fsub_out, fmix_out;
    logic [BLOCK_W-1:0] imix_out, isub_in, isub_out;
    logic [BLOCK_W-1:0] enc_next, dec_next;
    logic               busy_w, dec_w;

    assign dec_rnd = LAST_IDX - q.step;
    assign keyed   = q.state ^ subkey_i;

    spn_bitslice #(.INVERSE(1'b0)) u_fsub (
        .sel_i (q.step[2:0]),
        .din_i (keyed),
        .dout_o(fsub_out)
    );
    spn_mix #(.INVERSE(1'b0)) u_fmix (
        .din_i (fsub_out),
        .dout_o(fmix_out)
    );
    spn_mix #(.INVERSE(1'b1)) u_imix (
        .din_i (q.state),
        .dout_o(imix_out)
    );
    assign isub_in = (dec_rnd == TAIL_RND) ? q.state : imix_out;
    spn_bitslice #(.INVERSE(1'b1)) u_isub (
        .sel_i (dec_rnd[2:0]),
        .din_i (isub_in),
        .dout_o(isub_out)
    );

    always_comb begin
        if (q.step == LAST_IDX)       enc_next = keyed;
        else if (q.step == TAIL_RND)  enc_next = fsub_out;
        else                          enc_next = fmix_out;
        if (q.step == '0)             dec_next = keyed;
        else                          dec_next = isub_out ^ subkey_i;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.busy) begin
            d.state = q.dec ? dec_next : enc_next;
            if (q.step == LAST_IDX) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.step = '0;
            end else begin
                d.step = q.step + 1'b1;
            end
        end else if (start_i) begin
            d.busy  = 1'b1;
            d.dec   = decrypt_i;
            d.step  = '0;
            d.state = block_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign key_idx_o = !q.busy ? '0 : (q.dec ? dec_rnd : q.step);
    assign done_o    = q.done;
    assign block_o   = q.state;
    assign busy_w    = q.busy;
    assign dec_w     = q.dec;
endmodule

// File: rtl/spn_round_core_chk.sv
module spn_round_core_chk #(
    parameter int IDX_W = 6,
    parameter int LAST  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_o,
    input logic [IDX_W-1:0] key_idx_o,
    input logic             busy,
    input logic             dec
);
    localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_o);

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_idx_o <= LAST_V);

    assert_enc_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dec && key_idx_o != LAST_V) |=> (key_idx_o == $past(key_idx_o) + 1'b1));

    assert_dec_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dec && key_idx_o != '0) |=> (key_idx_o == $past(key_idx_o) - 1'b1));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (dec ? (key_idx_o != '0) : (key_idx_o != LAST_V))) |=> (busy && $stable(dec)));
endmodule

bind spn_round_core spn_round_core_chk #(.IDX_W(6), .LAST(NUM_ROUNDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_o   (done_o),
    .key_idx_o(key_idx_o),
    .busy     (busy_w),
    .dec      (dec_w)
);

// File: tb/spn_round_core_test.sv
module spn_round_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         decrypt_i = 1'b0;
    logic [127:0] block_i = '0;
    logic [5:0]   key_idx_o;
    logic [127:0] subkey_i;
    logic         done_o;
    logic [127:0] block_o;

    int total = 0;
    int bad = 0;
    logic [127:0] keys [33];

    int tbl [8][16] = '{
        '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12},
        '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4},
        '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2},
        '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14},
        '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13},
        '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1},
        '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0},
        '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}
    };

    always #5 clk = ~clk;

    spn_round_core uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
        .block_i(block_i), .key_idx_o(key_idx_o), .subkey_i(subkey_i),
        .done_o(done_o), .block_o(block_o)
    );

    always_comb subkey_i = (key_idx_o <= 6'd32) ? keys[key_idx_o] : '0;

    function automatic int look(int t, int v, bit inv);
        if (!inv) return tbl[t][v];
        for (int i = 0; i < 16; i++) if (tbl[t][i] == v) return i;
        return 0;
    endfunction

    function automatic logic [127:0] sub(logic [127:0] s, int t, bit inv);
        logic [127:0] o = '0;
        for (int j = 0; j < 32; j++) begin
            int v = {s[96+j], s[64+j], s[32+j], s[j]};
            int r = look(t, v, inv);
            o[j] = r[0]; o[32+j] = r[1]; o[64+j] = r[2]; o[96+j] = r[3];
        end
        return o;
    endfunction

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction
    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [127:0] mix(logic [127:0] s);
        logic [31:0] w0 = s[31:0], w1 = s[63:32], w2 = s[95:64], w3 = s[127:96];
        w0 = rl(w0, 13); w2 = rl(w2, 3);
        w1 ^= w0 ^ w2;   w3 ^= w2 ^ (w0 << 3);
        w1 = rl(w1, 1);  w3 = rl(w3, 7);
        w0 ^= w1 ^ w3;   w2 ^= w3 ^ (w1 << 7);
        w0 = rl(w0, 5);  w2 = rl(w2, 22);
        return {w3, w2, w1, w0};
    endfunction

    function automatic logic [127:0] unmix(logic [127:0] s);
        logic [31:0] w0 = s[31:0], w1 = s[63:32], w2 = s[95:64], w3 = s[127:96];
        w0 = rr(w0, 5);  w2 = rr(w2, 22);
        w0 ^= w1 ^ w3;   w2 ^= w3 ^ (w1 << 7);
        w1 = rr(w1, 1);  w3 = rr(w3, 7);
        w1 ^= w0 ^ w2;   w3 ^= w2 ^ (w0 << 3);
        w0 = rr(w0, 13); w2 = rr(w2, 3);
        return {w3, w2, w1, w0};
    endfunction

    function automatic logic [127:0] model(logic [127:0] p, bit inv);
        logic [127:0] s = p;
        if (!inv) begin
            for (int r = 0; r < 32; r++) begin
                s = sub(s ^ keys[r], r % 8, 1'b0);
                if (r < 31) s = mix(s);
            end
            s ^= keys[32];
        end else begin
            s ^= keys[32];
            for (int r = 31; r >= 0; r--) begin
                if (r < 31) s = unmix(s);
                s = sub(s, r % 8, 1'b1) ^ keys[r];
            end
        end
        return s;
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rnd_keys();
        for (int k = 0; k < 33; k++) keys[k] = {$urandom, $urandom, $urandom, $urandom};
    endtask

    task automatic launch(bit dec, logic [127:0] blk);
        start_i = 1'b1; decrypt_i = dec; block_i = blk;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Called at the negedge right after the accepting edge; returns at the done negedge.
    task automatic collect(bit dec, logic [127:0] exp, bit poke, string req, output logic [127:0] got);
        for (int i = 0; i <= 32; i++) begin
            int ei = dec ? 32 - i : i;
            chk(key_idx_o == 6'(ei), dec ? "R6/R7 key index" : "R4/R7 key index",
                128'(key_idx_o), 128'(ei));
            chk(done_o == 1'b0, "R2 done early", 128'(done_o), 128'd0);
            if (poke && i == 10) begin
                start_i = 1'b1; decrypt_i = ~dec; block_i = {$urandom, $urandom, $urandom, $urandom};
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk(done_o == 1'b1, "R2 done pulse", 128'(done_o), 128'd1);
        chk(block_o == exp, req, block_o, exp);
        got = block_o;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL R2 watchdog act=hung exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] p, c, r, e;
        void'($urandom(32'h5EED_1234));
        rnd_keys();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0, "R1 done reset", 128'(done_o), 128'd0);
        chk(key_idx_o == 6'd0, "R1 idx reset", 128'(key_idx_o), 128'd0);
        chk(block_o == '0, "R1 block reset", block_o, '0);

        // Directed: all-zero and all-one blocks exercise R3 column packing and R5 shifts.
        p = '0;
        launch(1'b0, p); collect(1'b0, model(p, 1'b0), 1'b0, "R3/R4/R5 enc zero", c);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done width", 128'(done_o), 128'd0);
        chk(block_o == c, "R9 result held", block_o, c);
        launch(1'b1, c); collect(1'b1, p, 1'b0, "R6 roundtrip zero", r);
        @(negedge clk);
        p = '1;
        launch(1'b0, p); collect(1'b0, model(p, 1'b0), 1'b0, "R3/R4/R5 enc ones", c);
        @(negedge clk);
        p = {32'h8000_0001, 32'h8000_0000, 32'hFFFF_0000, 32'h0000_0001};
        launch(1'b0, p); collect(1'b0, model(p, 1'b0), 1'b0, "R5 enc edge bits", c);
        @(negedge clk);

        // Random encrypt / decrypt with fresh keys.
        for (int n = 0; n < 12; n++) begin
            rnd_keys();
            p = {$urandom, $urandom, $urandom, $urandom};
            launch(1'b0, p); collect(1'b0, model(p, 1'b0), 1'b0, "R4 enc random", c);
            @(negedge clk);
            launch(1'b1, c); collect(1'b1, p, 1'b0, "R6 roundtrip random", r);
            @(negedge clk);
            e = {$urandom, $urandom, $urandom, $urandom};
            launch(1'b1, e); collect(1'b1, model(e, 1'b1), 1'b0, "R6 dec random", r);
            @(negedge clk);
        end

        // Start while busy: other direction and block must be ignored.
        p = {$urandom, $urandom, $urandom, $urandom};
        launch(1'b0, p); collect(1'b0, model(p, 1'b0), 1'b1, "R8 enc busy start", c);
        @(negedge clk);
        launch(1'b1, c); collect(1'b1, p, 1'b1, "R8 dec busy start", r);

        // Start in the same cycle as done: accepted back to back.
        e = {$urandom, $urandom, $urandom, $urandom};
        launch(1'b0, e);
        chk(done_o == 1'b0, "R9 done after restart", 128'(done_o), 128'd0);
        collect(1'b0, model(e, 1'b0), 1'b0, "R2 back-to-back enc", c);
        launch(1'b1, c);
        collect(1'b1, e, 1'b0, "R2 back-to-back dec", r);
        @(negedge clk);
        chk(key_idx_o == 6'd0, "R7 idle idx", 128'(key_idx_o), 128'd0);
        chk(block_o == e, "R9 result held idle", block_o, e);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule